// File: doc/BRIEF.md
# Residue Number Arithmetic Unit (moduli 8, 7, 5, 3)

This block does integer arithmetic in a residue number system built on the pairwise coprime moduli 8, 7, 5 and 3. The product of the moduli, 840, is the number of distinct values the system can hold. Operands arrive either as plain binary integers or as packed residue vectors. Binary operands are first split into their four remainders. The selected operation then runs on every channel at once. No channel passes a carry or any other value to another channel.

Each operation gives its result in both forms. The residue vector is rebuilt into a binary integer by Chinese-remainder reconstruction. Each residue is multiplied by its channel weight (105 for mod 8, 120 for mod 7, 336 for mod 5, 280 for mod 3), the four products are summed, and the sum is reduced modulo 840. A one-cycle start strobe launches an operation. A one-cycle done flag marks the new result, which then holds until the next start.

Top module: `rns_arith_unit`

## Requirements
- R1: While reset is asserted, and until the first operation after reset, `done_o` is 0 and both `y_bin_o` and `y_res_o` are 0.
- R2: A residue vector is 11 bits wide and packed as {mod-8 field [10:8], mod-7 field [7:5], mod-5 field [4:2], mod-3 field [1:0]}. Every field of `y_res_o` is canonical: it is less than its modulus.
- R3: With `res_fmt_i`=0, a binary operand v in 0..839 becomes the residues v mod 8, v mod 7, v mod 5 and v mod 3. For opcode 00 with B=0, the operation returns v unchanged in both forms.
- R4: `y_bin_o` equals (105·r8 + 120·r7 + 336·r5 + 280·r3) mod 840, where r8, r7, r5 and r3 are the fields of `y_res_o`. For example, the residue vector (1|2|4|0) gives 9.
- R5: Opcode 00 (add) gives (A+B) mod 840.
- R6: Opcode 01 (subtract) gives (A−B) mod 840, which wraps to a non-negative value.
- R7: Opcode 10 (multiply) gives (A·B) mod 840.
- R8: Opcode 11 (negate) gives (840−A) mod 840. Each residue is replaced by its complement with respect to its modulus, a zero residue stays zero, and operand B has no effect on the result.
- R9: With `res_fmt_i`=1, the operands are taken from `a_res_i`/`b_res_i`, and the binary operand inputs have no effect.
- R10: `done_o` is 1 exactly in the cycle after a cycle with `start_i`=1, and the result appears in that same cycle. While `start_i` is 0, both result outputs keep their values whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Launch an operation in this cycle |
| op_i | input | 2 | 00 add, 01 subtract, 10 multiply, 11 negate A |
| res_fmt_i | input | 1 | 0: operands taken in binary, 1: operands taken as residue vectors |
| a_bin_i | input | 10 | Operand A, binary |
| b_bin_i | input | 10 | Operand B, binary |
| a_res_i | input | 11 | Operand A, residue vector |
| b_res_i | input | 11 | Operand B, residue vector |
| done_o | output | 1 | Result valid pulse |
| y_bin_o | output | 10 | Result, binary (0..839) |
| y_res_o | output | 11 | Result, residue vector |

## Verification
On every cycle, assertions check the following. Each result field is canonical. The binary result stays below 840 and agrees with every residue field under reduction by that field's modulus. Outputs hold while no operation is launched. Negating a zero operand gives an all-zero vector. Only the bench scenarios can show the arithmetic itself: each operation is compared with integer arithmetic modulo 840. Every value 0..839 is converted forward and back. The (1|2|4|0) example gives 9. The bench also shows that B has no effect on negate and that the binary inputs have no effect when residue operands are selected.

// File: rtl/rns_pkg.sv
package rns_pkg;

  localparam int unsigned NUM_CH = 4;
  // channel 0 sits in the most significant field
  localparam int unsigned CH_MOD [NUM_CH] = '{8, 7, 5, 3};

  function automatic int unsigned dyn_range();
    int unsigned p;
    p = 1;
    for (int i = 0; i < NUM_CH; i++) p = p * CH_MOD[i];
    return p;
  endfunction

  function automatic int unsigned ch_width(int unsigned idx);
    return $clog2(CH_MOD[idx]);
  endfunction

  function automatic int unsigned ch_lsb(int unsigned idx);
    int unsigned pos;
    pos = 0;
    for (int i = 0; i < NUM_CH; i++)
      if (i > idx) pos = pos + $clog2(CH_MOD[i]);
    return pos;
  endfunction

  function automatic int unsigned res_width();
    int unsigned w;
    w = 0;
    for (int i = 0; i < NUM_CH; i++) w = w + $clog2(CH_MOD[i]);
    return w;
  endfunction

  // reconstruction weight: (M/m) times its inverse modulo m
  function automatic int unsigned crt_weight(int unsigned idx);
    int unsigned part, wgt;
    part = dyn_range() / CH_MOD[idx];
    wgt  = 0;
    for (int k = 1; k < 16; k++)
      if (wgt == 0 && k < CH_MOD[idx] && ((part * k) % CH_MOD[idx]) == 1) wgt = part * k;
    return wgt;
  endfunction

  localparam int unsigned DYN_RANGE = dyn_range();
  localparam int unsigned BIN_W     = $clog2(DYN_RANGE);
  localparam int unsigned RES_W     = res_width();

  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_MUL = 2'b10,
    OP_NEG = 2'b11
  } rns_op_e;

endpackage

// File: rtl/rns_fwd_conv.sv
module rns_fwd_conv
  import rns_pkg::*;
(
  input  logic [BIN_W-1:0] bin_i,
  output logic [RES_W-1:0] res_o
);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam int unsigned MOD = CH_MOD[ch];
    localparam int unsigned W   = ch_width(ch);
    localparam int unsigned LSB = ch_lsb(ch);
    if ((MOD & (MOD - 1)) == 0) begin : g_pow2
      // power-of-two modulus: remainder is the low bits
      assign res_o[LSB +: W] = bin_i[W-1:0];
    end else begin : g_gen
      assign res_o[LSB +: W] = W'(32'(bin_i) % MOD);
    end
  end

endmodule

// File: rtl/rns_chan_alu.sv
module rns_chan_alu
  import rns_pkg::*;
#(
  parameter int unsigned MOD = 7,
  parameter int unsigned W   = 3
) (
  input  rns_op_e        op_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [W-1:0]   y_o
);

  logic [31:0] a_n, b_n, raw;

  always_comb begin
    a_n = 32'(a_i) % MOD;
    b_n = 32'(b_i) % MOD;
    unique case (op_i)
      OP_ADD:  raw = a_n + b_n;
      OP_SUB:  raw = a_n + MOD - b_n;
      OP_MUL:  raw = a_n * b_n;
      default: raw = MOD - a_n;          // complement, zero maps to MOD then wraps to 0
    endcase
    y_o = W'(raw % MOD);
  end

endmodule

// File: rtl/rns_rev_conv.sv
module rns_rev_conv
  import rns_pkg::*;
(
  input  logic [RES_W-1:0] res_i,
  output logic [BIN_W-1:0] bin_o
);

  logic [31:0] part [NUM_CH];
  logic [31:0] acc;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam int unsigned W   = ch_width(ch);
    localparam int unsigned LSB = ch_lsb(ch);
    localparam int unsigned WGT = crt_weight(ch);
    assign part[ch] = 32'(res_i[LSB +: W]) * WGT;
  end

  always_comb begin
    acc = '0;
    for (int i = 0; i < NUM_CH; i++) acc = acc + part[i];
  end

  assign bin_o = BIN_W'(acc % DYN_RANGE);

endmodule

// File: rtl/rns_arith_unit.sv
module rns_arith_unit
  import rns_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [1:0]       op_i,
  input  logic             res_fmt_i,
  input  logic [BIN_W-1:0] a_bin_i,
  input  logic [BIN_W-1:0] b_bin_i,
  input  logic [RES_W-1:0] a_res_i,
  input  logic [RES_W-1:0] b_res_i,
  output logic             done_o,
  output logic [BIN_W-1:0] y_bin_o,
  output logic [RES_W-1:0] y_res_o
);

  // reset: asserted asynchronously, released through two flops
  logic rst_meta, rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_ns   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_ns   <= rst_meta;
    end
  end

  rns_op_e op;
  assign op = rns_op_e'(op_i);

  logic [RES_W-1:0] a_fwd, b_fwd, opa, opb, alu_res;
  logic [BIN_W-1:0] rev_bin;

  rns_fwd_conv u_fwd_a (.bin_i(a_bin_i), .res_o(a_fwd));
  rns_fwd_conv u_fwd_b (.bin_i(b_bin_i), .res_o(b_fwd));

  assign opa = res_fmt_i ? a_res_i : a_fwd;
  assign opb = res_fmt_i ? b_res_i : b_fwd;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_alu
    localparam int unsigned W   = ch_width(ch);
    localparam int unsigned LSB = ch_lsb(ch);
    rns_chan_alu #(.MOD(CH_MOD[ch]), .W(W)) u_alu (
      .op_i (op),
      .a_i  (opa[LSB +: W]),
      .b_i  (opb[LSB +: W]),
      .y_o  (alu_res[LSB +: W])
    );
  end

  rns_rev_conv u_rev (.res_i(alu_res), .bin_o(rev_bin));

  // next state
  logic             done_d;
  logic [BIN_W-1:0] y_bin_d;
  logic [RES_W-1:0] y_res_d;

  always_comb begin
    done_d  = start_i;
    y_bin_d = y_bin_o;
    y_res_d = y_res_o;
    if (start_i) begin
      y_bin_d = rev_bin;
      y_res_d = alu_res;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      done_o  <= 1'b0;
      y_bin_o <= '0;
      y_res_o <= '0;
    end else begin
      done_o  <= done_d;
      y_bin_o <= y_bin_d;
      y_res_o <= y_res_d;
    end
  end

  // ---------------- assertions ----------------
  assert_bin_in_range_R4: assert property (@(posedge clk) disable iff (!rst_ns)
    32'(y_bin_o) < DYN_RANGE);

  assert_hold_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_ns)
    !start_i |=> ($stable(y_bin_o) && $stable(y_res_o)));

  assert_neg_zero_stays_zero_R8: assert property (@(posedge clk) disable iff (!rst_ns)
    (start_i && op == OP_NEG && opa == '0) |=> (y_res_o == '0 && y_bin_o == '0));

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
    localparam int unsigned MOD = CH_MOD[ch];
    localparam int unsigned W   = ch_width(ch);
    localparam int unsigned LSB = ch_lsb(ch);

    assert_field_canonical_R2: assert property (@(posedge clk) disable iff (!rst_ns)
      32'(y_res_o[LSB +: W]) < MOD);

    assert_forms_agree_R4: assert property (@(posedge clk) disable iff (!rst_ns)
      (32'(y_bin_o) % MOD) == 32'(y_res_o[LSB +: W]));

    assert_fwd_canonical_R3: assert property (@(posedge clk) disable iff (!rst_ns)
      32'(a_fwd[LSB +: W]) < MOD);
  end

endmodule

// File: tb/rns_arith_unit_tb.sv
module rns_arith_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int RANGE      = 840;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [1:0]  op;
  logic        fmt;
  logic [9:0]  a_bin, b_bin;
  logic [10:0] a_res, b_res;
  logic        done;
  logic [9:0]  y_bin;
  logic [10:0] y_res;

  always #(CLK_PERIOD/2) clk = ~clk;

  rns_arith_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op), .res_fmt_i(fmt),
    .a_bin_i(a_bin), .b_bin_i(b_bin), .a_res_i(a_res), .b_res_i(b_res),
    .done_o(done), .y_bin_o(y_bin), .y_res_o(y_res)
  );

  int    checks = 0;
  int    fails  = 0;
  bit    finished = 0;
  int    cur_va, cur_vb;
  string cur_tag = "R1";

  // field order: mod 8 [10:8], mod 7 [7:5], mod 5 [4:2], mod 3 [1:0]
  function automatic logic [10:0] pack(int v);
    return {3'(v % 8), 3'(v % 7), 3'(v % 5), 2'(v % 3)};
  endfunction

  function automatic int ref_result(logic [1:0] o, int va, int vb);
    case (o)
      2'b00:   return (va + vb) % RANGE;
      2'b01:   return (va - vb + RANGE) % RANGE;
      2'b10:   return (va * vb) % RANGE;
      default: return (RANGE - va) % RANGE;
    endcase
  endfunction

  // reference model, advanced once per clock
  logic        exp_done;
  int          exp_val;
  string       exp_tag;
  bit          model_live = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_done <= 1'b0;
      exp_val  <= 0;
    end else begin
      exp_done <= start;
      if (start) exp_val <= ref_result(op, cur_va, cur_vb);
    end
    exp_tag    <= cur_tag;
    model_live <= 1'b1;
  end

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // compare every clock, a quarter period after the edge
  always begin
    @(posedge clk);
    #(CLK_PERIOD/4);
    if (model_live && !finished) begin
      check(exp_tag, "done", int'(done), int'(exp_done));
      check(exp_tag, "binary result", int'(y_bin), exp_val);
      check(exp_tag, "residue result", int'(y_res), int'(pack(exp_val)));
    end
  end

  task automatic drive(bit st, logic [1:0] o, int va, int vb, bit rf, string tag);
    @(negedge clk);
    start   = st;
    op      = o;
    fmt     = rf;
    cur_va  = va;
    cur_vb  = vb;
    cur_tag = tag;
    if (rf) begin
      a_res = pack(va);
      b_res = pack(vb);
      a_bin = 10'($urandom_range(1023));   // must be ignored (R9)
      b_bin = 10'($urandom_range(1023));
    end else begin
      a_bin = 10'(va);
      b_bin = 10'(vb);
      a_res = 11'($urandom_range(2047));
      b_res = 11'($urandom_range(2047));
    end
  endtask

  task automatic finish_run();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; op = 2'b00; fmt = 1'b0;
    a_bin = '0; b_bin = '0; a_res = '0; b_res = '0;
    cur_va = 0; cur_vb = 0;
    // R1: reset state observed during reset and while the internal release settles
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) drive(1'b0, 2'b00, 0, 0, 1'b0, "R1");

    // R3: every value converts forward and back unchanged
    for (int v = 0; v < RANGE; v++) drive(1'b1, 2'b00, v, 0, 1'b0, "R3");

    // R4: residue vector (1|2|4|0) reconstructs to 9
    @(negedge clk);
    start = 1'b1; op = 2'b00; fmt = 1'b1; cur_va = 9; cur_vb = 0; cur_tag = "R4";
    a_res = {3'd1, 3'd2, 3'd4, 2'd0}; b_res = '0; a_bin = 10'd500; b_bin = 10'd77;

    // R5 add, R6 subtract, R7 multiply
    for (int i = 0; i < 150; i++)
      drive(1'b1, 2'b00, $urandom_range(839), $urandom_range(839), i[0], "R5");
    drive(1'b1, 2'b00, 839, 1, 1'b0, "R5");
    for (int i = 0; i < 150; i++)
      drive(1'b1, 2'b01, $urandom_range(839), $urandom_range(839), i[0], "R6");
    drive(1'b1, 2'b01, 0, 839, 1'b0, "R6");
    drive(1'b1, 2'b01, 5, 5, 1'b1, "R6");
    for (int i = 0; i < 150; i++)
      drive(1'b1, 2'b10, $urandom_range(839), $urandom_range(839), i[0], "R7");
    drive(1'b1, 2'b10, 839, 839, 1'b0, "R7");
    drive(1'b1, 2'b10, 420, 2, 1'b1, "R7");

    // R8: negate, zero stays zero, B has no effect
    drive(1'b1, 2'b11, 0, 123, 1'b0, "R8");
    drive(1'b1, 2'b11, 0, 839, 1'b1, "R8");
    for (int i = 0; i < 100; i++)
      drive(1'b1, 2'b11, 1 + (i * 7) % 839, $urandom_range(839), i[0], "R8");

    // R9: residue operands with random binary inputs on the side
    for (int i = 0; i < 100; i++)
      drive(1'b1, 2'($urandom_range(3)), $urandom_range(839), $urandom_range(839), 1'b1, "R9");

    // R10: single launch, then idle cycles with moving inputs, outputs hold
    drive(1'b1, 2'b10, 17, 23, 1'b0, "R10");
    for (int i = 0; i < 20; i++)
      drive(1'b0, 2'($urandom_range(3)), $urandom_range(839), $urandom_range(839), i[0], "R10");
    drive(1'b1, 2'b01, 3, 10, 1'b1, "R10");
    drive(1'b0, 2'b00, 400, 400, 1'b0, "R10");
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule